// File: doc/BRIEF.md
# Coherence Controller with Temporally Invalid Lines

This block keeps the coherence state of a small table of cache lines for one processor on a snooping, bus-based multiprocessor. It runs the usual four-state protocol (Modified, Exclusive, Shared, Invalid) plus a fifth state, Temporally invalid (T). A line whose valid copy is taken away by another processor's write enters T rather than Invalid. When the writer later finds that its line has gone back to the value it held before the write, it broadcasts a version-only validate. Every T copy then becomes Shared again, and no data is moved.

The core side gives read, write and revert requests through a valid/ready port. A revert request means that reversion has been detected on a line this core owns. A request that needs the bus waits in the `WAIT_BUS` state of a two-state request machine (`IDLE`, `WAIT_BUS`). The machine drives one bus request under a valid/ready handshake, and the line's state changes on the grant edge. The snoop side applies bus read, read-exclusive, invalidate and validate transactions to the table, and gives a combinational "holds a copy" response.

Suppression of useless validates: when this core's write to a shared or absent line is granted, the bus's shared indication is stored with the line as a remote-copy flag. A revert request on a Modified line whose flag is clear ends at once, and no validate is sent. A probe port reads out any line's state.

Top module: `mesti_line_ctrl`

State codes: I=0, S=1, E=2, M=3, T=4. Local op codes: read=0, write=1, revert=2, 3=no operation. Bus and snoop op codes: read=0, read-exclusive=1, invalidate=2, validate=3.

## Requirements
- R1: After reset every line reads I on the probe port, `bus_req_valid` is low and `lcl_ready` is high.
- R2: A local read (op 0) to a line in M, E or S completes with no bus request and leaves the state unchanged. A read to T or I issues bus op 0 (read). On the grant the line becomes S if `bus_shared_in` is high and E if it is low.
- R3: A local write (op 1) in E moves to M with no bus request, and in M it stays M with no request. In S it issues bus op 2 (invalidate), and in T or I it issues bus op 1 (read-exclusive). After the grant the line is M.
- R4: A snooped read (op 0) moves M or E to S. `snp_shared_out` is high for a snooped line in M, E or S and low for a line in T or I. Transitions: snoop-read M->S, E->S.
- R5: A snooped read-exclusive (op 1) or invalidate (op 2) moves a line in M, E or S to T, never to I. T and I are unchanged.
- R6: A snooped validate (op 3) moves T to S. It leaves I as I and leaves M, E and S unchanged.
- R7: A local revert (op 2) on an M line whose remote-copy flag is set issues bus op 3 (validate). On the grant the line becomes S and the flag clears.
- R8: The remote-copy flag takes `bus_shared_in` at the grant of a local write, and a silent E->M write clears it. A revert on an M line whose flag is clear issues no bus request and the line stays M.
- R9: A revert on a line that is not M, and local op 3 on any line, issue no bus request and change no state.
- R10: While `bus_req_valid` is high and `bus_req_ready` is low, the request stays valid with a stable op and index, the line state does not change, and `lcl_ready` is low.
- R11: When a local state update and a snoop update hit the same line in one cycle, the local update wins.
- R12: If a pending validate's line is no longer M when the grant arrives, the line is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lcl_valid | input | 1 | Local request valid |
| lcl_ready | output | 1 | Controller can accept a local request |
| lcl_op | input | 2 | Local op: 0 read, 1 write, 2 revert, 3 none |
| lcl_idx | input | IW | Line index of the local request |
| bus_req_valid | output | 1 | Bus request valid |
| bus_req_ready | input | 1 | Bus grant |
| bus_req_op | output | 2 | Bus op: 0 read, 1 read-exclusive, 2 invalidate, 3 validate |
| bus_req_idx | output | IW | Line index of the bus request |
| bus_shared_in | input | 1 | Some remote cache holds the line, sampled at the grant |
| snp_valid | input | 1 | Snooped transaction valid |
| snp_op | input | 2 | Snooped op, encoded like the bus op |
| snp_idx | input | IW | Snooped line index |
| snp_shared_out | output | 1 | This cache holds a valid copy of the snooped line |
| probe_idx | input | IW | Line to read out |
| probe_state | output | 3 | State code of the probed line |

## Verification
On every cycle the assertions check the bus handshake's stability and the locking of the local port while a request is pending. They also check that the snoop response is low for stale lines, that invalidations land in T rather than I, that validates only revive T lines, that the local update wins a collision with a snoop, and that a revert with no recorded remote copies stays off the bus. The bench alone shows that whole sequences come out right against a reference model. These sequences include bus reads that end in E or S depending on the shared indication, the recording of the remote-copy flag across writes, and a validate whose line is invalidated while it waits for the grant.

// File: rtl/mesti_pkg.sv
package mesti_pkg;

    typedef enum logic [2:0] {
        LN_I = 3'd0,
        LN_S = 3'd1,
        LN_E = 3'd2,
        LN_M = 3'd3,
        LN_T = 3'd4
    } line_st_e;

    typedef enum logic [1:0] {
        LC_READ   = 2'd0,
        LC_WRITE  = 2'd1,
        LC_REVERT = 2'd2,
        LC_NOP    = 2'd3
    } lcl_op_e;

    typedef enum logic [1:0] {
        BX_READ  = 2'd0,
        BX_READX = 2'd1,
        BX_INVAL = 2'd2,
        BX_VALID = 2'd3
    } bus_op_e;

    function automatic logic holds_copy(line_st_e s);
        return (s == LN_M) || (s == LN_E) || (s == LN_S);
    endfunction

endpackage

// File: rtl/mesti_line_table.sv
module mesti_line_table
    import mesti_pkg::*;
#(
    parameter int NUM_LINES = 8,
    localparam int IW = $clog2(NUM_LINES)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      lw_en,
    input  logic [IW-1:0]             lw_idx,
    input  line_st_e                  lw_state,
    input  logic                      lw_flag_en,
    input  logic                      lw_flag,
    input  logic                      sw_en,
    input  logic [IW-1:0]             sw_idx,
    input  line_st_e                  sw_state,
    input  logic [IW-1:0]             ra_idx,
    output line_st_e                  ra_state,
    output logic                      ra_flag,
    input  logic [IW-1:0]             rb_idx,
    output line_st_e                  rb_state,
    input  logic [IW-1:0]             rc_idx,
    output line_st_e                  rc_state,
    input  logic [IW-1:0]             rd_idx,
    output line_st_e                  rd_state,
    output logic [NUM_LINES-1:0][2:0] st_all
);

    line_st_e             st_q [NUM_LINES];
    logic [NUM_LINES-1:0] flag_q;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic lw_hit;
        logic sw_hit;
        assign lw_hit = lw_en && (lw_idx == IW'(g));
        assign sw_hit = sw_en && (sw_idx == IW'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q[g]   <= LN_I;
                flag_q[g] <= 1'b0;
            end else begin
                if (lw_hit) begin
                    st_q[g] <= lw_state;
                end else if (sw_hit) begin
                    st_q[g] <= sw_state;
                end
                if (lw_flag_en && (lw_idx == IW'(g))) begin
                    flag_q[g] <= lw_flag;
                end
            end
        end

        assign st_all[g] = st_q[g];

        assert_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
            st_all[g] <= 3'd4)
            else $error("line %0d holds an illegal state code", g);

        // R11: local update wins over a snoop update of the same line
        assert_local_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (lw_hit && sw_hit) |=> (st_all[g] == $past(lw_state)))
            else $error("snoop overrode local update on line %0d", g);
    end

    assign ra_state = st_q[ra_idx];
    assign ra_flag  = flag_q[ra_idx];
    assign rb_state = st_q[rb_idx];
    assign rc_state = st_q[rc_idx];
    assign rd_state = st_q[rd_idx];

endmodule

// File: rtl/mesti_snoop_unit.sv
module mesti_snoop_unit
    import mesti_pkg::*;
(
    input  logic     snp_valid,
    input  bus_op_e  snp_op,
    input  line_st_e cur_state,
    output logic     wr_en,
    output line_st_e nxt_state,
    output logic     has_copy
);

    always_comb begin
        wr_en     = 1'b0;
        nxt_state = cur_state;
        has_copy  = snp_valid && holds_copy(cur_state);
        if (snp_valid) begin
            unique case (snp_op)
                BX_READ: begin
                    if (cur_state == LN_M || cur_state == LN_E) begin
                        wr_en     = 1'b1;
                        nxt_state = LN_S;
                    end
                end
                BX_READX, BX_INVAL: begin
                    if (holds_copy(cur_state)) begin
                        wr_en     = 1'b1;
                        nxt_state = LN_T;
                    end
                end
                BX_VALID: begin
                    if (cur_state == LN_T) begin
                        wr_en     = 1'b1;
                        nxt_state = LN_S;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/mesti_req_fsm.sv
module mesti_req_fsm
    import mesti_pkg::*;
#(
    parameter int NUM_LINES = 8,
    localparam int IW = $clog2(NUM_LINES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lcl_valid,
    input  lcl_op_e       lcl_op,
    input  logic [IW-1:0] lcl_idx,
    input  line_st_e      cur_state,
    input  logic          cur_flag,
    input  line_st_e      pend_state,
    output logic          lcl_ready,
    output logic          bus_req_valid,
    input  logic          bus_req_ready,
    output bus_op_e       bus_req_op,
    output logic [IW-1:0] bus_req_idx,
    input  logic          bus_shared_in,
    output logic          lw_en,
    output logic [IW-1:0] lw_idx,
    output line_st_e      lw_state,
    output logic          lw_flag_en,
    output logic          lw_flag,
    output logic [IW-1:0] pend_idx
);

    typedef enum logic {IDLE = 1'b0, WAIT_BUS = 1'b1} fsm_e;

    fsm_e          fsm_q, fsm_d;
    bus_op_e       pend_op_q;
    logic [IW-1:0] pend_idx_q;
    logic          start_bus;
    bus_op_e       start_op;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q      <= IDLE;
            pend_op_q  <= BX_READ;
            pend_idx_q <= '0;
        end else begin
            fsm_q <= fsm_d;
            if (fsm_q == IDLE && lcl_valid && start_bus) begin
                pend_op_q  <= start_op;
                pend_idx_q <= lcl_idx;
            end
        end
    end

    always_comb begin
        fsm_d         = fsm_q;
        lcl_ready     = 1'b0;
        bus_req_valid = 1'b0;
        start_bus     = 1'b0;
        start_op      = BX_READ;
        lw_en         = 1'b0;
        lw_idx        = lcl_idx;
        lw_state      = cur_state;
        lw_flag_en    = 1'b0;
        lw_flag       = 1'b0;
        unique case (fsm_q)
            IDLE: begin
                lcl_ready = 1'b1;
                if (lcl_valid) begin
                    unique case (lcl_op)
                        LC_READ: begin
                            if (!holds_copy(cur_state)) begin
                                start_bus = 1'b1;
                                start_op  = BX_READ;
                            end
                        end
                        LC_WRITE: begin
                            if (cur_state == LN_E) begin
                                lw_en      = 1'b1;
                                lw_state   = LN_M;
                                lw_flag_en = 1'b1;
                                lw_flag    = 1'b0;
                            end else if (cur_state == LN_S) begin
                                start_bus = 1'b1;
                                start_op  = BX_INVAL;
                            end else if (cur_state != LN_M) begin
                                start_bus = 1'b1;
                                start_op  = BX_READX;
                            end
                        end
                        LC_REVERT: begin
                            if (cur_state == LN_M && cur_flag) begin
                                start_bus = 1'b1;
                                start_op  = BX_VALID;
                            end
                        end
                        default: ;
                    endcase
                    if (start_bus) begin
                        fsm_d = WAIT_BUS;
                    end
                end
            end
            WAIT_BUS: begin
                bus_req_valid = 1'b1;
                lw_idx        = pend_idx_q;
                lw_state      = pend_state;
                if (bus_req_ready) begin
                    fsm_d = IDLE;
                    unique case (pend_op_q)
                        BX_READ: begin
                            lw_en    = 1'b1;
                            lw_state = bus_shared_in ? LN_S : LN_E;
                        end
                        BX_READX, BX_INVAL: begin
                            lw_en      = 1'b1;
                            lw_state   = LN_M;
                            lw_flag_en = 1'b1;
                            lw_flag    = bus_shared_in;
                        end
                        BX_VALID: begin
                            if (pend_state == LN_M) begin
                                lw_en      = 1'b1;
                                lw_state   = LN_S;
                                lw_flag_en = 1'b1;
                                lw_flag    = 1'b0;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            default: fsm_d = IDLE;
        endcase
    end

    assign bus_req_op  = pend_op_q;
    assign bus_req_idx = pend_idx_q;
    assign pend_idx    = pend_idx_q;

    // R10: request held stable until granted
    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && !bus_req_ready) |=>
            (bus_req_valid && $stable(bus_req_op) && $stable(bus_req_idx)))
        else $error("bus request dropped or changed before grant");

    // R10: local port locked while a request is outstanding
    assert_port_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid |-> !lcl_ready)
        else $error("local port ready during pending bus request");

    // R8, R9: revert without a recorded remote copy stays off the bus
    assert_revert_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lcl_valid && lcl_ready && lcl_op == LC_REVERT &&
         !(cur_state == LN_M && cur_flag)) |=> !bus_req_valid)
        else $error("validate issued without a remote copy");

endmodule

// File: rtl/mesti_line_ctrl.sv
module mesti_line_ctrl
    import mesti_pkg::*;
#(
    parameter int NUM_LINES = 8,
    localparam int IW = $clog2(NUM_LINES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lcl_valid,
    output logic          lcl_ready,
    input  logic [1:0]    lcl_op,
    input  logic [IW-1:0] lcl_idx,
    output logic          bus_req_valid,
    input  logic          bus_req_ready,
    output logic [1:0]    bus_req_op,
    output logic [IW-1:0] bus_req_idx,
    input  logic          bus_shared_in,
    input  logic          snp_valid,
    input  logic [1:0]    snp_op,
    input  logic [IW-1:0] snp_idx,
    output logic          snp_shared_out,
    input  logic [IW-1:0] probe_idx,
    output logic [2:0]    probe_state
);

    line_st_e                  lcl_state, snp_state, prb_state, pend_state;
    logic                      lcl_flag;
    logic                      lw_en, lw_flag_en, lw_flag;
    logic [IW-1:0]             lw_idx, pend_idx;
    line_st_e                  lw_state;
    logic                      sw_en;
    line_st_e                  sw_state;
    bus_op_e                   req_op;
    logic [NUM_LINES-1:0][2:0] st_all;
    logic                      same_line;

    mesti_line_table #(.NUM_LINES(NUM_LINES)) u_tbl (
        .clk        (clk),
        .rst_n      (rst_n),
        .lw_en      (lw_en),
        .lw_idx     (lw_idx),
        .lw_state   (lw_state),
        .lw_flag_en (lw_flag_en),
        .lw_flag    (lw_flag),
        .sw_en      (sw_en),
        .sw_idx     (snp_idx),
        .sw_state   (sw_state),
        .ra_idx     (lcl_idx),
        .ra_state   (lcl_state),
        .ra_flag    (lcl_flag),
        .rb_idx     (snp_idx),
        .rb_state   (snp_state),
        .rc_idx     (probe_idx),
        .rc_state   (prb_state),
        .rd_idx     (pend_idx),
        .rd_state   (pend_state),
        .st_all     (st_all)
    );

    mesti_snoop_unit u_snp (
        .snp_valid (snp_valid),
        .snp_op    (bus_op_e'(snp_op)),
        .cur_state (snp_state),
        .wr_en     (sw_en),
        .nxt_state (sw_state),
        .has_copy  (snp_shared_out)
    );

    mesti_req_fsm #(.NUM_LINES(NUM_LINES)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .lcl_valid     (lcl_valid),
        .lcl_op        (lcl_op_e'(lcl_op)),
        .lcl_idx       (lcl_idx),
        .cur_state     (lcl_state),
        .cur_flag      (lcl_flag),
        .pend_state    (pend_state),
        .lcl_ready     (lcl_ready),
        .bus_req_valid (bus_req_valid),
        .bus_req_ready (bus_req_ready),
        .bus_req_op    (req_op),
        .bus_req_idx   (bus_req_idx),
        .bus_shared_in (bus_shared_in),
        .lw_en         (lw_en),
        .lw_idx        (lw_idx),
        .lw_state      (lw_state),
        .lw_flag_en    (lw_flag_en),
        .lw_flag       (lw_flag),
        .pend_idx      (pend_idx)
    );

    assign bus_req_op  = req_op;
    assign probe_state = prb_state;
    assign same_line   = lw_en && (lw_idx == snp_idx);

    // R4: stale or absent lines never answer a snoop
    assert_no_stale_resp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && (snp_state == LN_T || snp_state == LN_I)) |-> !snp_shared_out)
        else $error("stale line answered a snoop");

    // R5: a remote write takes a valid copy to T, never to I
    assert_inval_to_t_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && (snp_op == 2'd1 || snp_op == 2'd2) &&
         holds_copy(snp_state) && !same_line) |=> (st_all[$past(snp_idx)] == 3'd4))
        else $error("snooped write did not leave the line temporally invalid");

    // R6: validate revives a T line to S
    assert_validate_t_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_op == 2'd3 && snp_state == LN_T && !same_line)
            |=> (st_all[$past(snp_idx)] == 3'd1))
        else $error("validate did not revive the line");

    // R6: validate leaves an invalid line invalid
    assert_validate_i_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_op == 2'd3 && snp_state == LN_I && !same_line)
            |=> (st_all[$past(snp_idx)] == 3'd0))
        else $error("validate touched an invalid line");

endmodule

// File: tb/mesti_line_ctrl_tb.sv
module mesti_line_ctrl_tb;

    localparam int NL = 8;
    localparam int IW = 3;

    localparam logic [2:0] SI = 3'd0, SS = 3'd1, SE = 3'd2, SM = 3'd3, ST = 3'd4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lcl_valid = 1'b0;
    logic          lcl_ready;
    logic [1:0]    lcl_op = 2'd0;
    logic [IW-1:0] lcl_idx = '0;
    logic          bus_req_valid;
    logic          bus_req_ready = 1'b0;
    logic [1:0]    bus_req_op;
    logic [IW-1:0] bus_req_idx;
    logic          bus_shared_in = 1'b0;
    logic          snp_valid = 1'b0;
    logic [1:0]    snp_op = 2'd0;
    logic [IW-1:0] snp_idx = '0;
    logic          snp_shared_out;
    logic [IW-1:0] probe_idx = '0;
    logic [2:0]    probe_state;

    int checks = 0;
    int errors = 0;

    logic [2:0] st_m [NL];
    logic       fl_m [NL];

    always #2 clk = ~clk;

    mesti_line_ctrl #(.NUM_LINES(NL)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .lcl_valid(lcl_valid), .lcl_ready(lcl_ready), .lcl_op(lcl_op), .lcl_idx(lcl_idx),
        .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
        .bus_req_op(bus_req_op), .bus_req_idx(bus_req_idx), .bus_shared_in(bus_shared_in),
        .snp_valid(snp_valid), .snp_op(snp_op), .snp_idx(snp_idx),
        .snp_shared_out(snp_shared_out), .probe_idx(probe_idx), .probe_state(probe_state)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit f_copy(logic [2:0] s);
        return (s == SM) || (s == SE) || (s == SS);
    endfunction

    function automatic bit f_need(logic [2:0] s, int op, bit fl);
        if (op == 0) return !f_copy(s);
        if (op == 1) return (s != SE) && (s != SM);
        if (op == 2) return (s == SM) && fl;
        return 1'b0;
    endfunction

    function automatic int f_bop(logic [2:0] s, int op);
        if (op == 0) return 0;
        if (op == 1) return (s == SS) ? 2 : 1;
        return 3;
    endfunction

    function automatic logic [2:0] f_snp_next(logic [2:0] s, int op);
        if (op == 0) return (s == SM || s == SE) ? SS : s;
        if (op == 3) return (s == ST) ? SS : s;
        return f_copy(s) ? ST : s;
    endfunction

    function automatic string f_tag(int op);
        if (op == 0) return "R2";
        if (op == 1) return "R3";
        if (op == 2) return "R7/R8";
        return "R9";
    endfunction

    task automatic do_local(input int op, input int idx, input int dly, input bit sh);
        logic [2:0] s;
        bit         need;
        int         bop;
        string      tg;
        s    = st_m[idx];
        need = f_need(s, op, fl_m[idx]);
        bop  = f_bop(s, op);
        tg   = f_tag(op);
        if (op == 2 && s != SM) tg = "R9";
        @(negedge clk);
        probe_idx = IW'(idx);
        lcl_valid = 1'b1;
        lcl_op    = 2'(op);
        lcl_idx   = IW'(idx);
        chk(lcl_ready == 1'b1, "R10 ready", int'(lcl_ready), 1);
        @(negedge clk);
        lcl_valid = 1'b0;
        if (need) begin
            chk(bus_req_valid == 1'b1, tg, int'(bus_req_valid), 1);
            chk(int'(bus_req_op) == bop && int'(bus_req_idx) == idx, tg,
                int'(bus_req_op), bop);
            for (int k = 0; k < dly; k++) begin
                chk(probe_state == s && lcl_ready == 1'b0, "R10 wait",
                    int'(probe_state), int'(s));
                @(negedge clk);
                chk(bus_req_valid && int'(bus_req_op) == bop, "R10 hold",
                    int'(bus_req_op), bop);
            end
            bus_req_ready = 1'b1;
            bus_shared_in = sh;
            @(negedge clk);
            bus_req_ready = 1'b0;
            bus_shared_in = 1'b0;
            if (bop == 0) begin
                st_m[idx] = sh ? SS : SE;
            end else if (bop == 3) begin
                if (st_m[idx] == SM) begin
                    st_m[idx] = SS;
                    fl_m[idx] = 1'b0;
                end
            end else begin
                st_m[idx] = SM;
                fl_m[idx] = sh;
            end
        end else begin
            chk(bus_req_valid == 1'b0, tg, int'(bus_req_valid), 0);
            if (op == 1 && s == SE) begin
                st_m[idx] = SM;
                fl_m[idx] = 1'b0;
            end
        end
        chk(probe_state == st_m[idx], tg, int'(probe_state), int'(st_m[idx]));
    endtask

    task automatic do_snoop(input int op, input int idx);
        string tg;
        tg = (op == 0) ? "R4" : (op == 3) ? "R6" : "R5";
        @(negedge clk);
        probe_idx = IW'(idx);
        snp_valid = 1'b1;
        snp_op    = 2'(op);
        snp_idx   = IW'(idx);
        #1;
        chk(snp_shared_out == f_copy(st_m[idx]), "R4 response",
            int'(snp_shared_out), int'(f_copy(st_m[idx])));
        @(negedge clk);
        snp_valid = 1'b0;
        st_m[idx] = f_snp_next(st_m[idx], op);
        chk(probe_state == st_m[idx], tg, int'(probe_state), int'(st_m[idx]));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        for (int i = 0; i < NL; i++) begin
            st_m[i] = SI;
            fl_m[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        for (int i = 0; i < NL; i++) begin
            probe_idx = IW'(i);
            #1;
            chk(probe_state == SI, "R1", int'(probe_state), 0);
        end
        chk(bus_req_valid == 1'b0 && lcl_ready == 1'b1, "R1 ports",
            int'(bus_req_valid), 0);

        // R2: read miss, E then S
        do_local(0, 0, 2, 1'b0);
        do_local(0, 1, 0, 1'b1);
        do_local(0, 0, 0, 1'b0);
        // R3: silent E->M, then R8 revert suppressed
        do_local(1, 0, 0, 1'b0);
        do_local(2, 0, 0, 1'b0);
        // R3: S upgrade with invalidate, remote copy recorded; R7 validate
        do_local(1, 1, 1, 1'b1);
        do_local(2, 1, 3, 1'b0);
        // R5 / R6: remote write to a shared line, then validate; validate on I
        do_snoop(2, 1);
        do_snoop(3, 1);
        do_snoop(3, 2);
        do_snoop(1, 0);
        do_local(0, 0, 1, 1'b1);
        // R4: snooped read of E
        do_local(0, 3, 0, 1'b0);
        do_snoop(0, 3);
        // R9: revert on S and no-op
        do_local(2, 3, 0, 1'b0);
        do_local(3, 3, 0, 1'b0);

        // R12: pending validate loses its line while waiting
        do_local(1, 5, 0, 1'b1);
        @(negedge clk);
        lcl_valid = 1'b1; lcl_op = 2'd2; lcl_idx = 3'd5; probe_idx = 3'd5;
        @(negedge clk);
        lcl_valid = 1'b0;
        chk(bus_req_valid && bus_req_op == 2'd3, "R7 issue", int'(bus_req_op), 3);
        snp_valid = 1'b1; snp_op = 2'd2; snp_idx = 3'd5;
        @(negedge clk);
        snp_valid = 1'b0;
        chk(probe_state == ST, "R5 during wait", int'(probe_state), int'(ST));
        bus_req_ready = 1'b1;
        @(negedge clk);
        bus_req_ready = 1'b0;
        chk(probe_state == ST, "R12", int'(probe_state), int'(ST));
        st_m[5] = ST;

        // R11: local silent write and snooped read collide on one line
        do_local(0, 6, 0, 1'b0);
        @(negedge clk);
        lcl_valid = 1'b1; lcl_op = 2'd1; lcl_idx = 3'd6;
        snp_valid = 1'b1; snp_op = 2'd0; snp_idx = 3'd6; probe_idx = 3'd6;
        @(negedge clk);
        lcl_valid = 1'b0; snp_valid = 1'b0;
        chk(probe_state == SM, "R11", int'(probe_state), int'(SM));
        st_m[6] = SM; fl_m[6] = 1'b0;

        // Constrained random mix
        for (int n = 0; n < 600; n++) begin
            int r;
            r = int'($urandom % 3);
            if (r < 2) begin
                do_local(int'($urandom % 4), int'($urandom % NL),
                         int'($urandom % 4), 1'($urandom % 2));
            end else begin
                do_snoop(int'($urandom % 4), int'($urandom % NL));
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule